// File: doc/BRIEF.md
# Pipeline Hazard and Exception Controller

This block is the combinational steering logic for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). From the opcodes held in decode, execute and memory, the decode source register IDs, the execute-stage load destination, the computed branch condition and the status codes of the two back stages, it decides every cycle whether each pipeline register loads normally, holds its content (stall) or loads a no-op (bubble). It also gates the execute-stage condition-code update.

Four special situations are recognised: a load or pop whose result is needed by the instruction in decode, a return travelling down the pipeline, a conditional jump that resolved not-taken after being predicted taken, and a faulting instruction in memory or write-back. When several occur together, fixed priorities apply. A load/use hazard wins over a return, so the return waits one more cycle in decode. A misprediction wins over a return found at the branch target. A separate error output flags any register that is asked to stall and bubble at once.

The pipeline registers sit outside this block. Each one holds on stall, loads a no-op on bubble and otherwise loads its input. The outputs here drive those three modes directly.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the execute opcode is LOAD (4'h3) or POP (4'h4) and its memory destination ID equals decode source A or source B, fetch stalls, decode stalls and execute gets a bubble.
- R2: A register ID of 4'hF means "no register" and never produces a load/use match, even when destination and source are both 4'hF.
- R3: While the RET opcode (4'h8) sits in decode, execute or memory, fetch stalls and decode gets a bubble.
- R4: When the execute opcode is JCC (4'h6) with a false condition, decode and execute both get a bubble, and fetch does not stall unless a return is also present.
- R5: When the memory status or the write-back status is ADR (2'd1), INS (2'd2) or HLT (2'd3), rather than OK (2'd0), memory gets a bubble and write-back stalls.
- R6: The condition-code enable is low in any cycle in which R5 applies, and high otherwise.
- R7: When a load/use hazard and a return occur together, decode stalls and does not get a bubble.
- R8: When a misprediction and a return occur together, decode and execute get bubbles and fetch stalls.
- R9: The error output is high only when some stage register would get stall and bubble together. No legal combination of inputs raises it.
- R10: With none of the four conditions present, every stall and bubble output is low and the condition-code enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_op | input | 4 | Opcode held in decode |
| e_op | input | 4 | Opcode held in execute |
| m_op | input | 4 | Opcode held in memory |
| e_ld_dst | input | 4 | Execute-stage memory-load destination ID (4'hF = none) |
| d_src_a | input | 4 | Decode source A ID (4'hF = none) |
| d_src_b | input | 4 | Decode source B ID (4'hF = none) |
| e_cond | input | 1 | Branch condition computed in execute |
| m_stat | input | 2 | Status produced by the memory stage |
| w_stat | input | 2 | Status held in write-back |
| f_stall | output | 1 | Hold fetch register |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Load no-op into decode register |
| e_bubble | output | 1 | Load no-op into execute register |
| m_bubble | output | 1 | Load no-op into memory register |
| w_stall | output | 1 | Hold write-back register |
| cc_en | output | 1 | Allow condition-code update in execute |
| ctl_err | output | 1 | A stage was asked to stall and bubble at once |

## Verification
The block holds no state, so a wrong internal decision shows on the outputs in the same evaluation as the input pattern that causes it, with no latency to hide it. The weak point is the interaction of conditions: a priority mistake appears only when two of them are present together, as a decode register that bubbles where it should hold, or as both requests at once on the error output. Every legal pairing of the four conditions is therefore driven and compared against values derived from the requirements, along with the "no register" ID cases.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int OPW  = 4;
  localparam int IDW  = 4;
  localparam int STW  = 2;
  localparam int NSTG = 5;

  localparam logic [OPW-1:0] OP_LOAD = 4'h3;
  localparam logic [OPW-1:0] OP_POP  = 4'h4;
  localparam logic [OPW-1:0] OP_JCC  = 4'h6;
  localparam logic [OPW-1:0] OP_RET  = 4'h8;
  localparam logic [IDW-1:0] ID_NONE = {IDW{1'b1}};

  typedef enum logic [STW-1:0] {
    ST_OK  = 2'd0,
    ST_ADR = 2'd1,
    ST_INS = 2'd2,
    ST_HLT = 2'd3
  } stat_e;

  typedef enum int {
    STG_F = 0,
    STG_D = 1,
    STG_E = 2,
    STG_M = 3,
    STG_W = 4
  } stage_e;

  typedef struct packed {
    logic stall;
    logic bubble;
  } stg_ctl_t;
endpackage

// File: rtl/hzc_detect.sv
module hzc_detect
  import hzc_pkg::*;
(
  input  logic [OPW-1:0] d_op,
  input  logic [OPW-1:0] e_op,
  input  logic [OPW-1:0] m_op,
  input  logic [IDW-1:0] e_ld_dst,
  input  logic [IDW-1:0] d_src_a,
  input  logic [IDW-1:0] d_src_b,
  input  logic           e_cond,
  input  logic [STW-1:0] m_stat,
  input  logic [STW-1:0] w_stat,
  output logic           hz_load_use,
  output logic           hz_ret,
  output logic           hz_mispred,
  output logic           hz_exc
);
  logic e_is_load;
  logic dst_valid;
  logic match_a;
  logic match_b;

  always_comb begin
    e_is_load   = (e_op == OP_LOAD) || (e_op == OP_POP);
    dst_valid   = (e_ld_dst != ID_NONE);
    match_a     = (d_src_a == e_ld_dst);
    match_b     = (d_src_b == e_ld_dst);
    hz_load_use = e_is_load && dst_valid && (match_a || match_b);
    hz_ret      = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    hz_mispred  = (e_op == OP_JCC) && !e_cond;
    hz_exc      = (m_stat != ST_OK) || (w_stat != ST_OK);
  end

  // R2
  always_comb begin
    none_match_chk: assert (!(hz_load_use && e_ld_dst == ID_NONE));
  end
endmodule

// File: rtl/hzc_actions.sv
module hzc_actions
  import hzc_pkg::*;
(
  input  logic     hz_load_use,
  input  logic     hz_ret,
  input  logic     hz_mispred,
  input  logic     hz_exc,
  output stg_ctl_t stg [NSTG],
  output logic     cc_en
);
  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      stg[i] = '0;
    end
    stg[STG_F].stall  = hz_load_use || hz_ret;
    stg[STG_D].stall  = hz_load_use;
    // load/use outranks a return: the return is held, not squashed
    stg[STG_D].bubble = hz_mispred || (hz_ret && !hz_load_use);
    stg[STG_E].bubble = hz_mispred || hz_load_use;
    stg[STG_M].bubble = hz_exc;
    stg[STG_W].stall  = hz_exc;
    cc_en             = !hz_exc;
  end

  // R7
  always_comb begin
    lu_ret_hold_chk: assert (!(hz_load_use && hz_ret) ||
                             (stg[STG_D].stall && !stg[STG_D].bubble));
  end

  // R8
  always_comb begin
    mis_ret_chk: assert (!(hz_mispred && hz_ret) ||
                         (stg[STG_D].bubble && stg[STG_E].bubble && stg[STG_F].stall));
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hzc_pkg::*;
(
  input  logic [3:0] d_op,
  input  logic [3:0] e_op,
  input  logic [3:0] m_op,
  input  logic [3:0] e_ld_dst,
  input  logic [3:0] d_src_a,
  input  logic [3:0] d_src_b,
  input  logic       e_cond,
  input  logic [1:0] m_stat,
  input  logic [1:0] w_stat,
  output logic       f_stall,
  output logic       d_stall,
  output logic       d_bubble,
  output logic       e_bubble,
  output logic       m_bubble,
  output logic       w_stall,
  output logic       cc_en,
  output logic       ctl_err
);
  logic     hz_load_use;
  logic     hz_ret;
  logic     hz_mispred;
  logic     hz_exc;
  stg_ctl_t stg [NSTG];
  logic [NSTG-1:0] clash;

  hzc_detect u_detect (
    .d_op        (d_op),
    .e_op        (e_op),
    .m_op        (m_op),
    .e_ld_dst    (e_ld_dst),
    .d_src_a     (d_src_a),
    .d_src_b     (d_src_b),
    .e_cond      (e_cond),
    .m_stat      (m_stat),
    .w_stat      (w_stat),
    .hz_load_use (hz_load_use),
    .hz_ret      (hz_ret),
    .hz_mispred  (hz_mispred),
    .hz_exc      (hz_exc)
  );

  hzc_actions u_actions (
    .hz_load_use (hz_load_use),
    .hz_ret      (hz_ret),
    .hz_mispred  (hz_mispred),
    .hz_exc      (hz_exc),
    .stg         (stg),
    .cc_en       (cc_en)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSTG; gi++) begin : g_clash
      assign clash[gi] = stg[gi].stall && stg[gi].bubble;
    end
  endgenerate

  assign ctl_err  = |clash;
  assign f_stall  = stg[STG_F].stall;
  assign d_stall  = stg[STG_D].stall;
  assign d_bubble = stg[STG_D].bubble;
  assign e_bubble = stg[STG_E].bubble;
  assign m_bubble = stg[STG_M].bubble;
  assign w_stall  = stg[STG_W].stall;

  // R9
  always_comb begin
    no_clash_chk: assert (!ctl_err);
  end

  // R6
  always_comb begin
    cc_gate_chk: assert (!(m_bubble && cc_en));
  end

  // R5
  always_comb begin
    exc_pair_chk: assert (m_bubble == w_stall);
  end
endmodule

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] LOAD = 4'h3, POP = 4'h4, JCC = 4'h6, RET = 4'h8, ADD = 4'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] d_op, e_op, m_op, e_ld_dst, d_src_a, d_src_b;
  logic e_cond;
  logic [1:0] m_stat, w_stat;
  logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_en, ctl_err;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_ctl uut (
    .d_op(d_op), .e_op(e_op), .m_op(m_op), .e_ld_dst(e_ld_dst),
    .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond(e_cond),
    .m_stat(m_stat), .w_stat(w_stat),
    .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .m_bubble(m_bubble), .w_stall(w_stall),
    .cc_en(cc_en), .ctl_err(ctl_err)
  );

  task automatic quiet();
    d_op = ADD; e_op = ADD; m_op = ADD;
    e_ld_dst = 4'hF; d_src_a = 4'h1; d_src_b = 4'h2;
    e_cond = 1'b1; m_stat = 2'd0; w_stat = 2'd0;
  endtask

  task automatic expect8(string req, logic [7:0] exp);
    logic [7:0] act;
    @(negedge clk);
    act = {f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_en, ctl_err};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {fs,ds,db,eb,mb,ws,cc,err} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_idle();
    quiet();
    expect8("R10 idle", 8'b0000_0010);
  endtask

  task automatic t_load_use();
    quiet(); e_op = LOAD; e_ld_dst = 4'h1;
    expect8("R1 load srcA", 8'b1101_0010);
    quiet(); e_op = POP; e_ld_dst = 4'h2;
    expect8("R1 pop srcB", 8'b1101_0010);
    quiet(); e_op = LOAD; e_ld_dst = 4'h5;
    expect8("R1 load no match", 8'b0000_0010);
    quiet(); e_op = ADD; e_ld_dst = 4'h1;
    expect8("R1 non-load match", 8'b0000_0010);
  endtask

  task automatic t_none_id();
    quiet(); e_op = LOAD; e_ld_dst = 4'hF; d_src_a = 4'hF; d_src_b = 4'hF;
    expect8("R2 none ids", 8'b0000_0010);
    quiet(); e_op = POP; e_ld_dst = 4'hF; d_src_a = 4'hF;
    expect8("R2 none srcA", 8'b0000_0010);
  endtask

  task automatic t_ret();
    quiet(); d_op = RET;
    expect8("R3 ret in D", 8'b1010_0010);
    quiet(); e_op = RET;
    expect8("R3 ret in E", 8'b1010_0010);
    quiet(); m_op = RET;
    expect8("R3 ret in M", 8'b1010_0010);
  endtask

  task automatic t_mispred();
    quiet(); e_op = JCC; e_cond = 1'b0;
    expect8("R4 mispredict", 8'b0011_0010);
    quiet(); e_op = JCC; e_cond = 1'b1;
    expect8("R4 taken ok", 8'b0000_0010);
  endtask

  task automatic t_exc();
    for (int s = 1; s < 4; s++) begin
      quiet(); m_stat = s[1:0];
      expect8("R5 R6 mem status", 8'b0000_1100);
      quiet(); w_stat = s[1:0];
      expect8("R5 R6 wb status", 8'b0000_1100);
    end
  endtask

  task automatic t_combos();
    for (int k = 0; k < 16; k++) begin
      logic lu, rt, ms, ex;
      lu = k[0]; rt = k[1]; ms = k[2]; ex = k[3];
      if (lu && ms) continue;
      quiet();
      if (lu) begin e_op = LOAD; e_ld_dst = 4'h2; end
      if (ms) begin e_op = JCC; e_cond = 1'b0; end
      if (rt) m_op = RET;
      if (ex) w_stat = 2'd2;
      expect8(lu && rt ? "R7 combo" : (ms && rt ? "R8 combo" : "R9 combo"),
              {lu | rt, lu, ms | (rt & ~lu), ms | lu, ex, ex, ~ex, 1'b0});
    end
  endtask

  initial begin
    quiet();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_load_use();
    t_none_id();
    t_ret();
    t_mispred();
    t_exc();
    t_combos();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule